// File: doc/BRIEF.md
# Pipelined Read Bus Slave

This block is a memory-mapped slave with a split command and response path. A master presents a command with chip select, address, read, write and write data. The slave uses a wait-request handshake only to decide whether it takes the command on that cycle. Read data comes back later as a single beat flagged by a data-valid strobe. Because of this split, a master can put the next read or write on the bus in the cycle after a read is taken, while earlier reads are still waiting for their data.

Behind the interface is a small bank of registers. When a read is taken, the slave copies the addressed register into a return queue. That queue holds up to four outstanding reads. Each entry carries a countdown, and it releases entries strictly oldest first. The countdown is either a fixed number of edges, set by a parameter, or a pseudo-random value from 1 to 4 drawn once per read. In both cases the data comes back in the order the reads were taken.

Top module: `rdbus_slave`

## Requirements
- R1: After a synchronous active-low reset, `rvalid` is low, `wait_req` is low while idle, no reads are outstanding, and every register reads back as zero.
- R2: A write is taken on any cycle with `cs` and `wr` high and `rd` low. It is never stalled, it updates the addressed register for all later reads, and it never produces an `rvalid` beat.
- R3: A read is taken on a cycle with `cs` and `rd` high and `wait_req` low. The data returned for it is the value the addressed register held on the cycle it was taken.
- R4: Every read that is taken produces exactly one cycle with `rvalid` high. Beats come back in the order the reads were taken, and `rvalid` is never raised without a read outstanding.
- R5: In fixed mode (`FIXED_LAT`=1), `rvalid` rises on the `LAT`-th clock edge after the edge that took the read.
- R6: In variable mode (`FIXED_LAT`=0), each read gets a delay of 1 to `VAR_MAX` edges (default 4), measured the same way as in R5, and ordering still holds.
- R7: `wait_req` is high exactly when `cs` and `rd` are high and `MAX_PEND` (4) reads are outstanding. A read is counted as outstanding from the edge that takes it up to the edge that raises its `rvalid`.
- R8: While `cs` is low, `wait_req` stays low and `rd` and `wr` are ignored: no register changes and no read is queued.
- R9: After a command is taken, a new command is taken on the very next cycle even while earlier reads are outstanding, as long as R7 does not stall it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select; gates all commands and the stall |
| addr | input | ADDR_W | Register index |
| rd | input | 1 | Read command |
| wr | input | 1 | Write command |
| wdata | input | DATA_W | Write data |
| wait_req | output | 1 | Command not taken this cycle; master must hold its command |
| rdata | output | DATA_W | Read data, valid when `rvalid` is high |
| rvalid | output | 1 | One beat per taken read |

## Verification
The bench runs a fixed-latency slave and a variable-latency slave side by side. Long runs of back-to-back reads push the fixed slave into its four-deep limit. A design that counted outstanding reads off by one would then stall early, which the per-cycle stall check reports. A design that overran the limit would lose or duplicate beats, which the scoreboard reports. Writes placed just before reads of the same register catch a slave that samples its data at release time instead of at acceptance. Commands issued with chip select low catch a slave that stalls or queues reads when it is not selected. The exact-latency check in fixed mode, and the 1-to-4 bound in variable mode, catch any countdown or ordering slip.

// File: rtl/rdbus_pkg.sv
// Shared helpers for the pipelined read slave.
// Assumes: an 8-bit maximal-length LFSR is enough to spread read delays.
package rdbus_pkg;

    typedef logic [7:0] lfsr_t;

    // Advance an 8-bit Fibonacci LFSR (taps 8,6,5,4) by one step.
    function automatic lfsr_t lfsr_step(input lfsr_t cur);
        return {cur[6:0], cur[7] ^ cur[5] ^ cur[4] ^ cur[3]};
    endfunction

endpackage

// File: rtl/rdbus_regfile.sv
// Register bank: 2**ADDR_W words, one write port, one combinational read port.
// Assumes: the caller qualifies we with chip select and stall.
module rdbus_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] words [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        // Hold one word; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (we && waddr == ADDR_W'(i))
                words[i] <= wdata;
        end
    end

    // Read mux.
    assign rdata = words[raddr];

endmodule

// File: rtl/rdbus_lat_gen.sv
// Per-read delay source: a constant LAT, or a pseudo-random 1..VAR_MAX.
// Assumes: advance pulses once for each taken read.
module rdbus_lat_gen
    import rdbus_pkg::*;
#(
    parameter bit   FIXED_LAT = 1'b1,
    parameter int   LAT       = 6,
    parameter int   VAR_MAX   = 4,
    parameter int   DLY_W     = 3,
    parameter lfsr_t SEED     = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [DLY_W-1:0] dly
);
    lfsr_t lfsr_q;
    logic [DLY_W-1:0] var_dly;

    // Step the generator once per taken read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else if (advance)
            lfsr_q <= lfsr_step(lfsr_q);
    end

    // Fold the LFSR state into the range 1..VAR_MAX.
    assign var_dly = DLY_W'((32'(lfsr_q) % VAR_MAX) + 1);

    // Select the delay that matches the latency mode.
    assign dly = FIXED_LAT ? DLY_W'(LAT) : var_dly;

    // Delay must stay within the allowed window.
    assert_dly_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dly >= DLY_W'(1)) && (FIXED_LAT || dly <= DLY_W'(VAR_MAX)));

endmodule

// File: rtl/rdbus_rtn_q.sv
// In-order return queue: DEPTH slots, each holding captured read data and a
// countdown. The oldest slot is released once its countdown reaches zero;
// younger slots count down meanwhile but never overtake it.
// Assumes: push is never raised while full; push_dly >= 1.
module rdbus_rtn_q #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int DLY_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic [DLY_W-1:0]             push_dly,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         rvalid,
    output logic [DATA_W-1:0]            rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH+1);

    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [OCC_W-1:0]  occ_q;
    logic              pop;
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DLY_W-1:0]  slot_cnt  [DEPTH];
    logic [DEPTH-1:0]  slot_vld;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] s_data;
        logic [DLY_W-1:0]  s_cnt;
        logic              s_vld;

        // Load on push, free on release, otherwise count down.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_vld  <= 1'b0;
                s_cnt  <= '0;
                s_data <= '0;
            end else if (push && wr_ptr == PTR_W'(i)) begin
                s_vld  <= 1'b1;
                s_cnt  <= push_dly - DLY_W'(1);
                s_data <= push_data;
            end else if (pop && rd_ptr == PTR_W'(i)) begin
                s_vld  <= 1'b0;
            end else if (s_vld && s_cnt != '0) begin
                s_cnt  <= s_cnt - DLY_W'(1);
            end
        end

        assign slot_data[i] = s_data;
        assign slot_cnt[i]  = s_cnt;
        assign slot_vld[i]  = s_vld;
    end

    // The oldest entry leaves once its countdown has expired.
    assign pop  = slot_vld[rd_ptr] && slot_cnt[rd_ptr] == '0;
    assign full = occ_q == OCC_W'(DEPTH);
    assign occ  = occ_q;

    // Advance the ring pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
        end
    end

    // Register the released beat onto the response outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= pop;
            if (pop)
                rdata <= slot_data[rd_ptr];
        end
    end

    // Occupancy never exceeds the number of slots.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH));

    // No push may land on a full queue.
    assert_push_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // A beat only appears if an entry was held before it.
    assert_beat_has_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(occ_q) != '0);

endmodule

// File: rtl/rdbus_slave.sv
// Pipelined read bus slave. Commands are taken under a wait-request
// handshake; read data is copied into an in-order return queue at acceptance
// and returned later as a single rvalid beat.
// Assumes: the master holds its command while wait_req is high and never
// raises rd and wr together.
module rdbus_slave
    import rdbus_pkg::*;
#(
    parameter int    DATA_W    = 32,
    parameter int    ADDR_W    = 3,
    parameter int    MAX_PEND  = 4,
    parameter bit    FIXED_LAT = 1'b1,
    parameter int    LAT       = 6,
    parameter int    VAR_MAX   = 4,
    parameter lfsr_t SEED      = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wait_req,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int MAXD  = (LAT > VAR_MAX) ? LAT : VAR_MAX;
    localparam int DLY_W = $clog2(MAXD + 1);
    localparam int OCC_W = $clog2(MAX_PEND + 1);

    logic              q_full;
    logic [OCC_W-1:0]  q_occ;
    logic              rd_take, wr_take;
    logic [DATA_W-1:0] reg_rdata;
    logic [DLY_W-1:0]  read_dly;

    // Stall only a selected read that finds the queue full.
    assign wait_req = cs && rd && q_full;
    assign rd_take  = cs && rd && !q_full;
    assign wr_take  = cs && wr && !rd;

    rdbus_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_take),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (reg_rdata)
    );

    rdbus_lat_gen #(
        .FIXED_LAT (FIXED_LAT),
        .LAT       (LAT),
        .VAR_MAX   (VAR_MAX),
        .DLY_W     (DLY_W),
        .SEED      (SEED)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rd_take),
        .dly     (read_dly)
    );

    rdbus_rtn_q #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_PEND),
        .DLY_W  (DLY_W)
    ) u_rtn (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_take),
        .push_data (reg_rdata),
        .push_dly  (read_dly),
        .full      (q_full),
        .occ       (q_occ),
        .rvalid    (rvalid),
        .rdata     (rdata)
    );

    // Deselected slave never stalls the master.
    assert_cs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !wait_req);

    // First cycle out of reset is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rvalid && q_occ == '0));

    // A stall means four reads really are outstanding.
    assert_stall_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> q_occ == OCC_W'(MAX_PEND));

endmodule

// File: tb/rdbus_slave_tb.sv
module rdbus_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wq0, wq1, rv0, rv1;
    logic [31:0] rd0, rd1;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] model [8];
    logic [31:0] expq [2][$];
    int          accq [2][$];
    int          outst [2];
    bit          live = 1'b0;

    always #10 clk = ~clk;

    rdbus_slave #(.FIXED_LAT(1'b1), .LAT(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .wait_req(wq0), .rdata(rd0), .rvalid(rv0));

    rdbus_slave #(.FIXED_LAT(1'b0), .VAR_MAX(4), .SEED(8'h3C)) u_dut_var (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .wait_req(wq1), .rdata(rd1), .rvalid(rv1));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog counts an expired run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Per-DUT monitor: beats, stall rule, acceptance.
    task automatic mon(input int k, input logic w, input logic v, input logic [31:0] dat);
        int lat;
        if (v) begin
            if (expq[k].size() == 0) begin
                check(1'b0, "R4 beat without read", 1, 0);
            end else begin
                check(dat == expq[k][0], "R3/R4 data in order", dat, expq[k][0]);
                lat = cyc - accq[k][0] - 1;
                if (k == 0) check(lat == 6, "R5 fixed latency", lat, 6);
                else        check(lat >= 1 && lat <= 4, "R6 variable latency", lat, 4);
                void'(expq[k].pop_front());
                void'(accq[k].pop_front());
                outst[k]--;
            end
        end
        check(w == (cs && rd && outst[k] == 4), cs ? "R7 stall rule" : "R8 no stall when deselected",
              w, cs && rd && outst[k] == 4);
        if (cs && rd && !w) begin
            expq[k].push_back(model[addr]);
            accq[k].push_back(cyc);
            outst[k]++;
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            mon(0, wq0, rv0, rd0);
            mon(1, wq1, rv1, rd1);
            if (cs && wr && !rd) model[addr] = wdata;   // R2 model update
        end
    end

    task automatic issue(input bit c, input bit r, input bit w, input logic [2:0] a,
                         input logic [31:0] d, output int stalls);
        @(posedge clk); #1;
        cs = c; rd = r; wr = w; addr = a; wdata = d; stalls = 0;
        forever begin
            @(negedge clk);
            if (!(wq0 || wq1)) break;
            stalls++;
            @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        int s;
        for (int i = 0; i < n; i++) issue(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, s);
    endtask

    initial begin
        int s;
        int roll;
        for (int i = 0; i < 8; i++) model[i] = '0;
        outst[0] = 0; outst[1] = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rv0 && !rv1, "R1 rvalid low after reset", {rv0, rv1}, 0);
        check(!wq0 && !wq1, "R1 wait low after reset", {wq0, wq1}, 0);
        live = 1'b1;

        // R1/R9: read every register back-to-back, expecting zeros
        for (int i = 0; i < 8; i++) issue(1'b1, 1'b1, 1'b0, 3'(i), 32'd0, s);
        idle(12);

        // R2: back-to-back writes, then read back (R3)
        for (int i = 0; i < 8; i++) issue(1'b1, 1'b0, 1'b1, 3'(i), 32'hA500_0000 + 32'(i * 17), s);
        for (int i = 7; i >= 0; i--) issue(1'b1, 1'b1, 1'b0, 3'(i), 32'd0, s);
        idle(12);

        // R9: four reads from idle are taken on consecutive cycles
        for (int i = 0; i < 4; i++) begin
            issue(1'b1, 1'b1, 1'b0, 3'(i), 32'd0, s);
            check(s == 0, "R9 back-to-back read taken", s, 0);
        end
        // R7: fifth read finds four outstanding in fixed mode and stalls
        issue(1'b1, 1'b1, 1'b0, 3'd4, 32'd0, s);
        check(s > 0, "R7 fifth read stalled", s, 1);
        // R3: write then immediate read of same register sees new value
        issue(1'b1, 1'b0, 1'b1, 3'd2, 32'hDEAD_BEEF, s);
        check(s == 0, "R2 write never stalled", s, 0);
        issue(1'b1, 1'b1, 1'b0, 3'd2, 32'd0, s);
        idle(12);

        // R8: deselected commands are ignored
        issue(1'b0, 1'b0, 1'b1, 3'd3, 32'h1234_5678, s);
        issue(1'b0, 1'b1, 1'b0, 3'd3, 32'd0, s);
        issue(1'b0, 1'b1, 1'b0, 3'd5, 32'd0, s);
        idle(10);
        check(expq[0].size() == 0 && expq[1].size() == 0, "R8 no read queued when deselected",
              expq[0].size() + expq[1].size(), 0);
        issue(1'b1, 1'b1, 1'b0, 3'd3, 32'd0, s);   // R8: expects old value of reg 3
        idle(10);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            roll = int'($urandom_range(0, 9));
            if (roll < 5)      issue(1'b1, 1'b1, 1'b0, 3'($urandom_range(0, 7)), 32'd0, s);
            else if (roll < 8) issue(1'b1, 1'b0, 1'b1, 3'($urandom_range(0, 7)), $urandom, s);
            else if (roll < 9) issue(1'b0, 1'($urandom_range(0, 1)), 1'b0, 3'($urandom_range(0, 7)), $urandom, s);
            else               issue(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, s);
        end
        idle(16);

        // R4: every taken read produced its beat
        check(expq[0].size() == 0, "R4 fixed slave drained", expq[0].size(), 0);
        check(expq[1].size() == 0, "R4 variable slave drained", expq[1].size(), 0);
        finish_run();
    end
endmodule